// File: doc/BRIEF.md
# Multi-Mode Floppy Controller Host Register Bank

This block holds the eight host-visible byte registers of a PC-style floppy disk controller (offsets 0 to 7 from its base). It decodes synchronous read and write strobes from the host side. It keeps the drive-select, motor, DMA-enable and reset controls, and it holds the data rate, the write precompensation and low-power state. It also assembles the status bytes that the host reads back. The FIFO data port and the main status byte come from the command engine: for offset 4, the bank passes `msr_in` to the bus, and for offset 5 it only watches accesses.

The meaning, polarity and presence of each status bit depend on a three-way interface mode. Plain mode (`if_mode`=0, and also 3) hides both status registers and drives only one bit of the input register. Direct mode (`if_mode`=1) shows the live drive signals and two toggle bits. Latched mode (`if_mode`=2) shows inverted signals and several sticky bits that set on signal edges and clear when the input register is read. Each byte lane has its own output enable, so that undriven bits can float on the shared bus.

Top module: `fdc_regbank`

## Requirements
- R1: After a hardware reset, `drv_sel`=0, `mot_en`=0, `dma_en`=0, `rate`=2 (the rate register reads 02h), `precomp`=0, `low_power`=0, offset 2 reads 00h, and `sw_reset` is 1 because the reset-bar bit is 0.
- R2: A write to offset 2 sets `drv_sel` from bits 1:0, `sw_reset` to the inverse of bit 2, `dma_en` from bit 3 and `mot_en` from bits 7:4. The byte reads back unchanged and no software reset alters it.
- R3: A write to offset 4 with bit 7 set raises `sw_reset` for exactly one cycle. The same write loads `precomp` from bits 4:2 and `rate` from bits 1:0.
- R4: A write to offset 4 with bit 6 set enters low power. A read of offset 4, any access to offset 5, or any software reset ends it.
- R5: Both a write to offset 7 (bits 1:0) and a write to offset 4 set `rate`, and the later write decides. The rate encoding is 0=500k, 1=300k, 2=250k, 3=1M.
- R6: In plain mode, reads of offsets 0 and 1 drive no bit (`io_oe`=00h). A read of offset 7 drives only bit 7, which is the inverse of `dskchg_n`. `io_oe` is 00h whenever no read is in progress.
- R7: In direct mode, offset 0 reads {irq, 1, step, trk0_n, side, index_n, wprot_n, seek}, listed from bit 7 to bit 0.
- R8: In direct mode, offset 1 reads {1, 1, drive-select bit 0, write-data toggle, read-data toggle, wgate, motor 1, motor 0}. Each toggle flips on every falling edge of its data signal.
- R9: In direct mode, offset 7 reads {~dskchg_n, 1111, rate[1:0], dens}, where dens is 0 for the 500k or 1M rate and 1 otherwise.
- R10: In latched mode, offset 0 reads {irq, drq, step latch, ~trk0_n, ~side, ~index_n, ~wprot_n, ~seek}. The step latch sets when `step_act` rises and clears on a read of offset 7 or on a software reset.
- R11: In latched mode, offset 1 reads {1, ds1_n, ds0_n, wdata latch, rdata latch, wgate latch, ds3_n, ds2_n}, where dsN_n is 0 only for the drive that `drv_sel` picks. The wgate latch sets on the rising edge of wgate, and the data latches set on the falling edges of their signals. A read of offset 7 clears all three.
- R12: In latched mode, offset 7 reads {~dskchg_n, 000, dma_en, noprec, rate[1:0]}. Bit 2 of an offset-7 write sets noprec.
- R13: Offset 3 holds a two-bit tape select (bits 1:0). With `tdr_ext`=0 only bits 1:0 are driven. With `tdr_ext`=1 it reads {00, the drive type of the selected drive from `drv_type_cfg`[2n+1:2n], `boot_drv`, tape select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| if_mode | input | 2 | 0 plain, 1 direct, 2 latched, 3 plain |
| tdr_ext | input | 1 | Extended tape register layout |
| drv_type_cfg | input | 8 | Two-bit type per drive |
| boot_drv | input | 2 | Boot drive number |
| io_addr | input | 3 | Register offset |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, masked by io_oe |
| io_oe | output | 8 | Per-bit bus drive enable |
| msr_in | input | 8 | Main status byte from command engine |
| dskchg_n | input | 1 | Disk change, active low |
| wprot_n | input | 1 | Write protect, active low |
| index_n | input | 1 | Index, active low |
| trk0_n | input | 1 | Track zero, active low |
| step_act | input | 1 | Step output, active high |
| seek_in | input | 1 | Head direction, 1 inward |
| side_sel | input | 1 | Head select, 1 side one |
| wgate_act | input | 1 | Write gate, active high |
| wrdata_act | input | 1 | Write data, active high |
| rddata_act | input | 1 | Read data, active high |
| fdc_irq | input | 1 | Controller interrupt |
| dma_req | input | 1 | DMA request |
| drv_sel | output | 2 | Selected drive |
| mot_en | output | 4 | Motor enables |
| dma_en | output | 1 | DMA enable |
| sw_reset | output | 1 | Software reset to controller core |
| rate | output | 2 | Data rate select |
| precomp | output | 3 | Write precompensation select |
| low_power | output | 1 | Low-power state |

## Verification
Read data is combinational, so the bench compares a read in the same cycle as its strobe, just before the edge that applies any clear-on-read. Written controls and the rate reach the outputs one edge after the write strobe. The one-cycle software reset pulse from offset 4 shows in the cycle after the write and is gone a cycle later. Any latch or low-power clear that follows from a software reset takes one more edge, so the bench idles a cycle before it reads the result. For edge-driven bits, the bench moves a pin on a falling clock and lets one rising edge pass for each level. It checks a status byte only after the edge that records the transition.

// File: rtl/fdc_regbank.sv
module fdc_regbank #(
  parameter logic [1:0] RATE_RST = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] if_mode,
  input  logic       tdr_ext,
  input  logic [7:0] drv_type_cfg,
  input  logic [1:0] boot_drv,
  input  logic [2:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic [7:0] io_oe,
  input  logic [7:0] msr_in,
  input  logic       dskchg_n,
  input  logic       wprot_n,
  input  logic       index_n,
  input  logic       trk0_n,
  input  logic       step_act,
  input  logic       seek_in,
  input  logic       side_sel,
  input  logic       wgate_act,
  input  logic       wrdata_act,
  input  logic       rddata_act,
  input  logic       fdc_irq,
  input  logic       dma_req,
  output logic [1:0] drv_sel,
  output logic [3:0] mot_en,
  output logic       dma_en,
  output logic       sw_reset,
  output logic [1:0] rate,
  output logic [2:0] precomp,
  output logic       low_power
);
  localparam logic [2:0] A_SRA = 3'd0, A_SRB = 3'd1, A_DOR = 3'd2, A_TDR = 3'd3,
                         A_MSR = 3'd4, A_DAT = 3'd5, A_DIR = 3'd7;

  logic [7:0] dor;
  logic [1:0] tape_sel;
  logic       noprec, kick;
  logic       step_q, wg_q, rd_q, wd_q;
  logic       step_l, wg_l, rd_l, wd_l, rd_t, wd_t;
  logic [7:0] rv, oe;

  wire m_dir = (if_mode == 2'd1);
  wire m_lat = (if_mode == 2'd2);
  wire wr_dor = io_wr && io_addr == A_DOR;
  wire wr_tdr = io_wr && io_addr == A_TDR;
  wire wr_dsr = io_wr && io_addr == A_MSR;
  wire wr_ccr = io_wr && io_addr == A_DIR;
  wire rd_dir = io_rd && io_addr == A_DIR;
  wire wake   = (io_rd && io_addr == A_MSR) || ((io_rd || io_wr) && io_addr == A_DAT);
  wire step_r = step_act && !step_q;
  wire wg_r   = wgate_act && !wg_q;
  wire rd_f   = !rddata_act && rd_q;
  wire wd_f   = !wrdata_act && wd_q;

  assign drv_sel  = dor[1:0];
  assign mot_en   = dor[7:4];
  assign dma_en   = dor[3];
  assign sw_reset = !dor[2] || kick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dor <= '0; tape_sel <= '0; noprec <= 1'b0; kick <= 1'b0;
      rate <= RATE_RST; precomp <= '0; low_power <= 1'b0;
      step_q <= 1'b0; wg_q <= 1'b0; rd_q <= 1'b0; wd_q <= 1'b0;
      step_l <= 1'b0; wg_l <= 1'b0; rd_l <= 1'b0; wd_l <= 1'b0;
      rd_t <= 1'b0; wd_t <= 1'b0;
    end else begin
      kick <= wr_dsr && io_wdata[7];
      if (wr_dor) dor <= io_wdata;
      if (wr_tdr) tape_sel <= io_wdata[1:0];
      if (wr_dsr) begin
        rate    <= io_wdata[1:0];
        precomp <= io_wdata[4:2];
      end
      if (wr_ccr) begin
        rate   <= io_wdata[1:0];
        noprec <= io_wdata[2];
      end
      if (sw_reset || wake) low_power <= 1'b0;
      else if (wr_dsr)      low_power <= io_wdata[6];
      step_q <= step_act; wg_q <= wgate_act; rd_q <= rddata_act; wd_q <= wrdata_act;
      if (step_r) step_l <= 1'b1;
      else if (rd_dir || sw_reset) step_l <= 1'b0;
      if (wg_r) wg_l <= 1'b1;
      else if (rd_dir) wg_l <= 1'b0;
      if (rd_f) rd_l <= 1'b1;
      else if (rd_dir) rd_l <= 1'b0;
      if (wd_f) wd_l <= 1'b1;
      else if (rd_dir) wd_l <= 1'b0;
      if (rd_f) rd_t <= !rd_t;
      if (wd_f) wd_t <= !wd_t;
    end
  end

  always_comb begin
    rv = '0;
    oe = '0;
    if (io_rd) begin
      case (io_addr)
        A_SRA: begin
          if (m_dir) begin
            oe = 8'hFF;
            rv = {fdc_irq, 1'b1, step_act, trk0_n, side_sel, index_n, wprot_n, seek_in};
          end else if (m_lat) begin
            oe = 8'hFF;
            rv = {fdc_irq, dma_req, step_l, !trk0_n, !side_sel, !index_n, !wprot_n, !seek_in};
          end
        end
        A_SRB: begin
          if (m_dir) begin
            oe = 8'hFF;
            rv = {2'b11, dor[0], wd_t, rd_t, wgate_act, dor[5], dor[4]};
          end else if (m_lat) begin
            oe = 8'hFF;
            rv = {1'b1, dor[1:0] != 2'd1, dor[1:0] != 2'd0, wd_l, rd_l, wg_l,
                  dor[1:0] != 2'd3, dor[1:0] != 2'd2};
          end
        end
        A_DOR: begin
          oe = 8'hFF;
          rv = dor;
        end
        A_TDR: begin
          oe = tdr_ext ? 8'hFF : 8'h03;
          rv = {2'b00, drv_type_cfg[{dor[1:0], 1'b0} +: 2], boot_drv, tape_sel};
        end
        A_MSR: begin
          oe = 8'hFF;
          rv = msr_in;
        end
        A_DIR: begin
          if (m_dir) begin
            oe = 8'hFF;
            rv = {!dskchg_n, 4'hF, rate, !(rate == 2'd0 || rate == 2'd3)};
          end else if (m_lat) begin
            oe = 8'hFF;
            rv = {!dskchg_n, 3'b000, dor[3], noprec, rate};
          end else begin
            oe = 8'h80;
            rv = {!dskchg_n, 7'b0};
          end
        end
        default: ;
      endcase
    end
  end

  assign io_rdata = rv & oe;
  assign io_oe    = oe;
endmodule

// File: rtl/fdc_regbank_chk.sv
module fdc_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] if_mode,
  input logic       tdr_ext,
  input logic [2:0] io_addr,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_oe,
  input logic [1:0] drv_sel,
  input logic [3:0] mot_en,
  input logic       sw_reset,
  input logic [1:0] rate,
  input logic       low_power
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> drv_sel == 2'd0 && mot_en == 4'd0 && rate == 2'd2 && !low_power && sw_reset);
  // R2
  dor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == 3'd2 |=> drv_sel == $past(io_wdata[1:0]) && mot_en == $past(io_wdata[7:4]));
  // R3
  dsr_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == 3'd4 && io_wdata[7] |=> sw_reset);
  // R4
  lp_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == 3'd4 |=> !low_power);
  // R5
  ccr_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == 3'd7 |=> rate == $past(io_wdata[1:0]));
  // R6
  plain_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd0) && io_rd && io_addr[2:1] == 2'b00 |-> io_oe == 8'h00);
  // R6
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_oe == 8'h00);
  // R13
  tdr_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tdr_ext && io_rd && io_addr == 3'd3 |-> io_oe == 8'h03);
endmodule

bind fdc_regbank fdc_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_mode(if_mode), .tdr_ext(tdr_ext),
  .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_oe(io_oe), .drv_sel(drv_sel), .mot_en(mot_en), .sw_reset(sw_reset),
  .rate(rate), .low_power(low_power)
);

// File: tb/sim_fdc_regbank.sv
module sim_fdc_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] if_mode = 2'd0;
  logic tdr_ext = 1'b0;
  logic [7:0] drv_type_cfg = 8'b11_10_01_00;
  logic [1:0] boot_drv = 2'b10;
  logic [2:0] io_addr = 3'd0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, io_oe;
  logic [7:0] msr_in = 8'h80;
  logic dskchg_n = 1'b0, wprot_n = 1'b0, index_n = 1'b1, trk0_n = 1'b0;
  logic step_act = 1'b0, seek_in = 1'b1, side_sel = 1'b1;
  logic wgate_act = 1'b0, wrdata_act = 1'b0, rddata_act = 1'b0;
  logic fdc_irq = 1'b1, dma_req = 1'b0;
  logic [1:0] drv_sel, rate;
  logic [3:0] mot_en;
  logic [2:0] precomp;
  logic dma_en, sw_reset, low_power;

  int vectors = 0, miscompares = 0;
  logic mon_go = 1'b0, done = 1'b0;
  int q_kind[$];
  int q_sel[$];
  logic [7:0] q_d[$];
  logic [7:0] q_oe[$];
  string q_tag[$];

  always #10 clk = ~clk;

  fdc_regbank u0 (
    .clk(clk), .rst_n(rst_n), .if_mode(if_mode), .tdr_ext(tdr_ext),
    .drv_type_cfg(drv_type_cfg), .boot_drv(boot_drv), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_oe(io_oe), .msr_in(msr_in), .dskchg_n(dskchg_n), .wprot_n(wprot_n),
    .index_n(index_n), .trk0_n(trk0_n), .step_act(step_act), .seek_in(seek_in),
    .side_sel(side_sel), .wgate_act(wgate_act), .wrdata_act(wrdata_act),
    .rddata_act(rddata_act), .fdc_irq(fdc_irq), .dma_req(dma_req),
    .drv_sel(drv_sel), .mot_en(mot_en), .dma_en(dma_en), .sw_reset(sw_reset),
    .rate(rate), .precomp(precomp), .low_power(low_power)
  );

  function automatic logic [7:0] out_field(int sel);
    case (sel)
      0: return {6'd0, drv_sel};
      1: return {4'd0, mot_en};
      2: return {7'd0, dma_en};
      3: return {6'd0, rate};
      4: return {5'd0, precomp};
      5: return {7'd0, sw_reset};
      default: return {7'd0, low_power};
    endcase
  endfunction

  always begin
    @(negedge clk);
    #5;
    while (mon_go && q_kind.size() > 0) begin
      int k, s;
      logic [7:0] d, m;
      string t;
      k = q_kind.pop_front(); s = q_sel.pop_front();
      d = q_d.pop_front(); m = q_oe.pop_front(); t = q_tag.pop_front();
      vectors++;
      if (k == 0) begin
        if (io_oe !== m || (io_rdata & m) !== (d & m)) begin
          miscompares++;
          $display("FAIL %s: read data %h oe %h, expected data %h oe %h", t, io_rdata, io_oe, d & m, m);
        end
      end else if (out_field(s) !== d) begin
        miscompares++;
        $display("FAIL %s: output field %0d is %h, expected %h", t, s, out_field(s), d);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] d, logic [7:0] m, string t);
    io_addr = a; io_rd = 1'b1;
    q_kind.push_back(0); q_sel.push_back(0); q_d.push_back(d); q_oe.push_back(m); q_tag.push_back(t);
    mon_go = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; mon_go = 1'b0;
  endtask

  task automatic out_chk(int s, logic [7:0] d, string t);
    q_kind.push_back(1); q_sel.push_back(s); q_d.push_back(d); q_oe.push_back(8'h00); q_tag.push_back(t);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; idle(1); sig = 1'b0; idle(1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    out_chk(0, 8'd0, "R1 drv_sel"); out_chk(1, 8'd0, "R1 mot_en");
    out_chk(2, 8'd0, "R1 dma_en");  out_chk(3, 8'd2, "R1 rate");
    out_chk(4, 8'd0, "R1 precomp"); out_chk(5, 8'd1, "R1 sw_reset");
    out_chk(6, 8'd0, "R1 low_power");
    rd_chk(3'd2, 8'h00, 8'hFF, "R1 dor read");
    // R2 control register
    wr(3'd2, 8'h3D);
    out_chk(0, 8'd1, "R2 drv_sel"); out_chk(1, 8'd3, "R2 mot_en");
    out_chk(2, 8'd1, "R2 dma_en");  out_chk(5, 8'd0, "R2 sw_reset");
    rd_chk(3'd2, 8'h3D, 8'hFF, "R2 dor readback");
    // R3 self-clearing reset from rate register
    wr(3'd4, 8'h8D);
    out_chk(5, 8'd1, "R3 kick high");
    out_chk(5, 8'd0, "R3 kick gone");
    out_chk(3, 8'd1, "R3 rate"); out_chk(4, 8'd3, "R3 precomp");
    rd_chk(3'd2, 8'h3D, 8'hFF, "R2 dor kept over sw reset");
    // R5 last writer sets rate
    wr(3'd7, 8'h03);
    out_chk(3, 8'd3, "R5 rate from ccr"); out_chk(4, 8'd3, "R5 precomp kept");
    wr(3'd4, 8'h00);
    out_chk(3, 8'd0, "R5 rate from dsr");
    // R4 low power entry and exits
    wr(3'd4, 8'h40);
    out_chk(6, 8'd1, "R4 lp on");
    rd_chk(3'd4, 8'h80, 8'hFF, "R4 msr read");
    out_chk(6, 8'd0, "R4 lp off by msr read");
    wr(3'd4, 8'h42);
    out_chk(6, 8'd1, "R4 lp on again");
    wr(3'd5, 8'h00);
    out_chk(6, 8'd0, "R4 lp off by data access");
    wr(3'd4, 8'h40);
    wr(3'd2, 8'h39);
    out_chk(5, 8'd1, "R2 sw_reset from dor bit2");
    out_chk(6, 8'd0, "R4 lp off by sw reset");
    wr(3'd2, 8'h3D);
    // R6 plain mode
    rd_chk(3'd0, 8'h00, 8'h00, "R6 sra floats");
    rd_chk(3'd1, 8'h00, 8'h00, "R6 srb floats");
    rd_chk(3'd7, 8'h80, 8'h80, "R6 dir bit7 only");
    // R13 tape register
    wr(3'd3, 8'h02);
    rd_chk(3'd3, 8'h02, 8'h03, "R13 tdr narrow");
    tdr_ext = 1'b1;
    rd_chk(3'd3, 8'h1A, 8'hFF, "R13 tdr extended");
    tdr_ext = 1'b0;
    // R7 R8 R9 direct mode
    if_mode = 2'd1;
    rd_chk(3'd0, 8'hCD, 8'hFF, "R7 sra direct");
    rd_chk(3'd1, 8'hE3, 8'hFF, "R8 srb direct");
    pulse(rddata_act);
    rd_chk(3'd1, 8'hEB, 8'hFF, "R8 read toggle");
    pulse(wrdata_act);
    rd_chk(3'd1, 8'hFB, 8'hFF, "R8 write toggle");
    pulse(rddata_act);
    rd_chk(3'd1, 8'hF3, 8'hFF, "R8 read toggle back");
    rd_chk(3'd7, 8'hF8, 8'hFF, "R9 dir 500k");
    wr(3'd7, 8'h02);
    rd_chk(3'd7, 8'hFD, 8'hFF, "R9 dir 250k");
    // R10 latched mode status A
    if_mode = 2'd2;
    rd_chk(3'd0, 8'h92, 8'hFF, "R10 sra latched");
    pulse(step_act);
    rd_chk(3'd0, 8'hB2, 8'hFF, "R10 step latched");
    rd_chk(3'd7, 8'h8A, 8'hFF, "R12 dir latched");
    rd_chk(3'd0, 8'h92, 8'hFF, "R10 step cleared by dir read");
    pulse(step_act);
    rd_chk(3'd0, 8'hB2, 8'hFF, "R10 step latched again");
    wr(3'd4, 8'h82);
    idle(1);
    rd_chk(3'd0, 8'h92, 8'hFF, "R10 step cleared by sw reset");
    // R11 latched mode status B
    rd_chk(3'd1, 8'hA3, 8'hFF, "R11 srb latched");
    wgate_act = 1'b1; idle(1);
    rd_chk(3'd1, 8'hA7, 8'hFF, "R11 wgate latch");
    pulse(rddata_act);
    rd_chk(3'd1, 8'hAF, 8'hFF, "R11 rdata latch");
    rd_chk(3'd7, 8'h8A, 8'hFF, "R12 dir clears latches");
    rd_chk(3'd1, 8'hA3, 8'hFF, "R11 latches cleared");
    wgate_act = 1'b0;
    // R12 latched mode input register
    wr(3'd7, 8'h07);
    rd_chk(3'd7, 8'h8F, 8'hFF, "R12 noprec and 1M");
    dskchg_n = 1'b1; idle(1);
    rd_chk(3'd7, 8'h0F, 8'hFF, "R12 no disk change");
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule